// File: doc/BRIEF.md
# Broadcast Message Receiver and Type Matcher

This block sits behind a link deframer. It receives one byte per strobe and finds framed broadcast messages in that stream. Fill bytes of value 0xCC separate the messages. A message starts with a start byte that packs the length and a 2-bit checksum. The block writes the message bytes into a ring of fixed-size blocks in a 16-bit word RAM. It checks that a fill byte closes the message, and it compares the 16-bit message type against a bank of programmable event registers.

When a well-framed message carries a type held in any event register, the block loads a pointer word with the start address of the block that holds it. If the interrupt enable is set, it also raises a message interrupt. A malformed start byte, or a missing closing fill byte, raises a separate error interrupt. Software services both interrupts and acknowledges each one on its own strobe. Software reaches the block through a word-addressed register bus with separate read and write strobes. The bus gives access to the pointer, a vector word, the enable bit, the event registers and the stored messages.

Top module: `msgrx_receiver`

## Requirements
- R1: After reset, both interrupt requests are low. Reads of word 0x00 (pointer), 0x01 (vector) and 0x02 (enable) return 0.
- R2: Word 0x01 stores all 16 bits written to it. Word 0x02 keeps only bit 0, which is the interrupt enable. Words 0x08 to 0x0F are eight event registers that read back what was written. Writes to word 0x00 and to the buffer words 0x10 to 0x7F have no effect.
- R3: A byte with its two top bits at 00 opens a message only when the byte received directly before it was 0xCC. At any other time, such bytes are dropped without storing anything or raising an interrupt.
- R4: In the start byte, bits 5:2 give the count of bytes that follow and bits 1:0 give a checksum. The checksum must equal the number of ones in the count, modulo 4, and the count must be at least 2. A start byte that breaks either rule is a framing error.
- R5: When the count runs out, the next byte must be 0xCC. Any other value is a framing error and the message is discarded. The next valid message then lands in the same block.
- R6: Byte k of the message body (k counted from 0, type high byte first) goes to word block_base + k/2. Even k goes to the high byte and odd k to the low byte, so the type fills the first word of the block.
- R7: A valid message whose type equals any event register loads word 0x00 with the start address of its block, one cycle after the closing fill byte. The first two valid messages give 0x10 and then 0x18.
- R8: A valid message that matches no event register still uses up a block, but it leaves the pointer and the message interrupt unchanged.
- R9: The 14 blocks of 8 words are used in order from 0x10 to 0x78. After 0x78 the next block is 0x10 again.
- R10: A request is raised only while the enable bit is 1. The message request follows a matching valid message, and the error request follows a framing error. Each request stays high until its own acknowledge strobe. The acknowledge for one request does not clear the other.
- R11: Read data for a read strobe appears on the data output in the next cycle. It holds its value until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Strobe marking a valid received byte |
| rx_byte | input | 8 | Received byte from the deframer |
| bus_addr | input | 7 | Word address of a register access |
| bus_wdata | input | 16 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 16 | Registered read data |
| msg_ack | input | 1 | Acknowledge for the message interrupt |
| err_ack | input | 1 | Acknowledge for the error interrupt |
| msg_irq | output | 1 | Message interrupt request |
| err_irq | output | 1 | Error interrupt request |

## Verification
The pointer, the stored bytes and the message request all change at the clock edge that takes the closing fill byte. The error request changes at the edge that takes the bad byte. The bench therefore samples the interrupt lines at the falling edge that follows the last byte it drove. Register reads take one cycle: the read task queues the expected word when it raises the strobe. A monitor then pops and compares that word at the falling edge one cycle later, so each result is checked in exactly the cycle it is due.

// File: rtl/msgrx_pkg.sv
package msgrx_pkg;

   localparam logic [7:0] FILL_BYTE = 8'hCC;

   typedef enum logic [1:0] {
      FR_HUNT,
      FR_ARMED,
      FR_BODY,
      FR_TAIL
   } fr_state_t;

   function automatic logic [1:0] len_check(input logic [3:0] len);
      return 2'($countones(len));
   endfunction

endpackage

// File: rtl/msgrx_deframer.sv
module msgrx_deframer
   import msgrx_pkg::*;
#(
   parameter int BLOCKS      = 14,
   parameter int BLOCK_WORDS = 8,
   localparam int BLK_W  = $clog2(BLOCKS),
   localparam int OFF_W  = $clog2(BLOCK_WORDS * 2),
   localparam int BUF_AW = $clog2(BLOCKS * BLOCK_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_valid,
   input  logic [7:0]        byte_in,
   output logic              wr_en,
   output logic [BUF_AW-1:0] wr_addr,
   output logic              wr_hi,
   output logic [15:0]       msg_type,
   output logic              msg_done,
   output logic              frame_err,
   output logic [BLK_W-1:0]  blk_idx
);

   if (BLOCK_WORDS * 2 < 15) begin : g_chk_block
      $error("BLOCK_WORDS too small for the longest message");
   end

   fr_state_t        st_q;
   logic [3:0]       cnt_q;
   logic [OFF_W-1:0] off_q;
   logic [BLK_W-1:0] blk_q;
   logic [15:0]      type_q;

   logic       is_fill, is_start, start_good, start_bad, tail_bad;
   logic [3:0] len;

   always_comb begin
      is_fill    = (byte_in == FILL_BYTE);
      is_start   = (byte_in[7:6] == 2'b00);
      len        = byte_in[5:2];
      start_good = byte_valid && st_q == FR_ARMED && is_start &&
                   byte_in[1:0] == len_check(len) && len >= 4'd2;
      start_bad  = byte_valid && st_q == FR_ARMED && is_start && !start_good;
      tail_bad   = byte_valid && st_q == FR_TAIL && !is_fill;
      msg_done   = byte_valid && st_q == FR_TAIL && is_fill;
      frame_err  = start_bad || tail_bad;
      wr_en      = byte_valid && st_q == FR_BODY;
      wr_hi      = ~off_q[0];
      wr_addr    = BUF_AW'(blk_q) * BUF_AW'(BLOCK_WORDS) + BUF_AW'(off_q >> 1);
   end

   assign msg_type = type_q;
   assign blk_idx  = blk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= FR_HUNT;
         cnt_q  <= '0;
         off_q  <= '0;
         blk_q  <= '0;
         type_q <= '0;
      end else if (byte_valid) begin
         unique case (st_q)
            FR_HUNT: begin
               if (is_fill) st_q <= FR_ARMED;
            end
            FR_ARMED: begin
               if (start_good) begin
                  st_q  <= FR_BODY;
                  cnt_q <= len;
                  off_q <= '0;
               end else if (!is_fill) begin
                  st_q <= FR_HUNT;
               end
            end
            FR_BODY: begin
               if (off_q == OFF_W'(0)) type_q[15:8] <= byte_in;
               if (off_q == OFF_W'(1)) type_q[7:0]  <= byte_in;
               off_q <= off_q + OFF_W'(1);
               cnt_q <= cnt_q - 4'd1;
               if (cnt_q == 4'd1) st_q <= FR_TAIL;
            end
            FR_TAIL: begin
               if (is_fill) begin
                  st_q  <= FR_ARMED;
                  blk_q <= (blk_q == BLK_W'(BLOCKS - 1)) ? '0 : blk_q + BLK_W'(1);
               end else begin
                  st_q <= FR_HUNT;
               end
            end
            default: st_q <= FR_HUNT;
         endcase
      end
   end

endmodule

// File: rtl/msgrx_event_bank.sv
module msgrx_event_bank #(
   parameter int EVENTS = 8,
   parameter int DW     = 16,
   localparam int EV_W  = $clog2(EVENTS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [EV_W-1:0] wr_sel,
   input  logic [DW-1:0]   wr_data,
   input  logic [EV_W-1:0] rd_sel,
   output logic [DW-1:0]   rd_data,
   input  logic [DW-1:0]   probe,
   output logic            hit
);

   logic [DW-1:0]     ev_all [EVENTS];
   logic [EVENTS-1:0] hits;

   for (genvar g = 0; g < EVENTS; g++) begin : g_ev
      logic [DW-1:0] val_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                  val_q <= '0;
         else if (wr_en && wr_sel == EV_W'(g))        val_q <= wr_data;
      end
      assign ev_all[g] = val_q;
      assign hits[g]   = (val_q == probe);
   end

   assign hit     = |hits;
   assign rd_data = ev_all[rd_sel];

endmodule

// File: rtl/msgrx_msg_ram.sv
module msgrx_msg_ram #(
   parameter int WORDS = 112,
   localparam int AW   = $clog2(WORDS)
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic          wr_hi,
   input  logic [7:0]    wr_byte,
   input  logic [AW-1:0] rd_addr,
   output logic [15:0]   rd_data
);

   logic [15:0] mem [WORDS];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         if (wr_hi) mem[wr_addr][15:8] <= wr_byte;
         else       mem[wr_addr][7:0]  <= wr_byte;
      end
   end

   assign rd_data = mem[rd_addr];

endmodule

// File: rtl/msgrx_receiver.sv
module msgrx_receiver
   import msgrx_pkg::*;
#(
   parameter int EVENTS      = 8,
   parameter int BLOCKS      = 14,
   parameter int BLOCK_WORDS = 8,
   parameter int AW          = 7,
   parameter int DW          = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rx_valid,
   input  logic [7:0]    rx_byte,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_wdata,
   input  logic          bus_wr,
   input  logic          bus_rd,
   output logic [DW-1:0] bus_rdata,
   input  logic          msg_ack,
   input  logic          err_ack,
   output logic          msg_irq,
   output logic          err_irq
);

   localparam int BUF_WORDS = BLOCKS * BLOCK_WORDS;
   localparam int BUF_AW    = $clog2(BUF_WORDS);
   localparam int BLK_W     = $clog2(BLOCKS);
   localparam int EV_W      = $clog2(EVENTS);
   localparam logic [AW-1:0] EV_BASE  = AW'(8);
   localparam logic [AW-1:0] EV_END   = AW'(8 + EVENTS);
   localparam logic [AW-1:0] BUF_BASE = AW'(16);

   if (DW != 16) begin : g_chk_dw
      $error("data width must be 16");
   end
   if (EVENTS < 2 || EVENTS > 8) begin : g_chk_ev
      $error("EVENTS must lie in 2..8");
   end
   if (16 + BUF_WORDS > (1 << AW) || BUF_AW > AW) begin : g_chk_map
      $error("buffer does not fit the address space");
   end

   logic              wr_en, wr_hi, msg_done, frame_err, hit;
   logic [BUF_AW-1:0] wr_addr;
   logic [15:0]       msg_type;
   logic [BLK_W-1:0]  blk_idx;
   logic [DW-1:0]     ev_rd, ram_rd, rd_mux;
   logic [AW-1:0]     buf_off;
   logic              ev_wr;

   logic [DW-1:0] ptr_q, vec_q;
   logic          mask_q;
   logic          msg_set, err_set;

   msgrx_deframer #(
      .BLOCKS      (BLOCKS),
      .BLOCK_WORDS (BLOCK_WORDS)
   ) u_deframer (
      .clk        (clk),
      .rst_n      (rst_n),
      .byte_valid (rx_valid),
      .byte_in    (rx_byte),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_hi      (wr_hi),
      .msg_type   (msg_type),
      .msg_done   (msg_done),
      .frame_err  (frame_err),
      .blk_idx    (blk_idx)
   );

   assign ev_wr   = bus_wr && bus_addr >= EV_BASE && bus_addr < EV_END;
   assign buf_off = bus_addr - BUF_BASE;

   msgrx_event_bank #(
      .EVENTS (EVENTS),
      .DW     (DW)
   ) u_events (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (ev_wr),
      .wr_sel  (bus_addr[EV_W-1:0]),
      .wr_data (bus_wdata),
      .rd_sel  (bus_addr[EV_W-1:0]),
      .rd_data (ev_rd),
      .probe   (msg_type),
      .hit     (hit)
   );

   msgrx_msg_ram #(
      .WORDS (BUF_WORDS)
   ) u_ram (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_hi   (wr_hi),
      .wr_byte (rx_byte),
      .rd_addr (BUF_AW'(buf_off)),
      .rd_data (ram_rd)
   );

   assign msg_set = msg_done && hit && mask_q;
   assign err_set = frame_err && mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q   <= '0;
         vec_q   <= '0;
         mask_q  <= 1'b0;
         msg_irq <= 1'b0;
         err_irq <= 1'b0;
      end else begin
         if (msg_done && hit)
            ptr_q <= DW'(BUF_BASE) + DW'(blk_idx) * DW'(BLOCK_WORDS);
         if (bus_wr && bus_addr == AW'(1)) vec_q  <= bus_wdata;
         if (bus_wr && bus_addr == AW'(2)) mask_q <= bus_wdata[0];
         if (msg_set)      msg_irq <= 1'b1;
         else if (msg_ack) msg_irq <= 1'b0;
         if (err_set)      err_irq <= 1'b1;
         else if (err_ack) err_irq <= 1'b0;
      end
   end

   always_comb begin
      rd_mux = '0;
      if (bus_addr >= BUF_BASE) begin
         if (buf_off < AW'(BUF_WORDS)) rd_mux = ram_rd;
      end else if (bus_addr >= EV_BASE) begin
         if (bus_addr < EV_END) rd_mux = ev_rd;
      end else begin
         case (bus_addr)
            AW'(0):  rd_mux = ptr_q;
            AW'(1):  rd_mux = vec_q;
            AW'(2):  rd_mux = {{(DW-1){1'b0}}, mask_q};
            default: rd_mux = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_mux;
   end

endmodule

// File: rtl/msgrx_checker.sv
module msgrx_checker #(
   parameter int BLOCKS      = 14,
   parameter int BLOCK_WORDS = 8,
   parameter int BLK_W       = 4,
   parameter int DW          = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             msg_irq,
   input logic             err_irq,
   input logic             msg_ack,
   input logic             err_ack,
   input logic             mask_q,
   input logic             msg_set,
   input logic             err_set,
   input logic [DW-1:0]    ptr_q,
   input logic [BLK_W-1:0] blk_idx,
   input logic             bus_rd,
   input logic [DW-1:0]    bus_rdata
);

   // R10
   msg_rise_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(msg_irq) |-> $past(mask_q));

   // R10
   err_rise_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_irq) |-> $past(mask_q));

   // R10
   msg_ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_ack && !msg_set) |=> !msg_irq);

   // R10
   err_ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_ack && !err_set) |=> !err_irq);

   // R7
   ptr_on_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ptr_q) |-> (ptr_q % BLOCK_WORDS == 0 && ptr_q >= 16 &&
                           ptr_q < 16 + BLOCKS * BLOCK_WORDS));

   // R9
   blk_in_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(blk_idx) < BLOCKS);

   // R11
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bus_rd) |-> $stable(bus_rdata));

endmodule

bind msgrx_receiver msgrx_checker #(
   .BLOCKS      (BLOCKS),
   .BLOCK_WORDS (BLOCK_WORDS),
   .BLK_W       ($clog2(BLOCKS)),
   .DW          (DW)
) u_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .msg_irq   (msg_irq),
   .err_irq   (err_irq),
   .msg_ack   (msg_ack),
   .err_ack   (err_ack),
   .mask_q    (mask_q),
   .msg_set   (msg_set),
   .err_set   (err_set),
   .ptr_q     (ptr_q),
   .blk_idx   (blk_idx),
   .bus_rd    (bus_rd),
   .bus_rdata (bus_rdata)
);

// File: tb/test_msgrx_receiver.sv
`timescale 1ns/1ps
module test_msgrx_receiver;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_byte = 8'h00;
   logic [6:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [15:0] bus_rdata;
   logic        msg_ack = 1'b0;
   logic        err_ack = 1'b0;
   logic        msg_irq, err_irq;

   int errs = 0;
   int checks = 0;

   logic [15:0] exp_q[$];
   string       tag_q[$];
   logic        rd_seen = 1'b0;

   always #2 clk = ~clk;

   msgrx_receiver i_msgrx_receiver (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_valid  (rx_valid),
      .rx_byte   (rx_byte),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_rdata (bus_rdata),
      .msg_ack   (msg_ack),
      .err_ack   (err_ack),
      .msg_irq   (msg_irq),
      .err_irq   (err_irq)
   );

   always @(posedge clk) rd_seen <= bus_rd;

   // monitor: compares each read one cycle after its strobe
   always @(negedge clk) begin
      if (rd_seen === 1'b1) begin
         if (exp_q.size() == 0) begin
            errs++;
            checks++;
            $display("FAIL R11: read data %h with no expected item", bus_rdata);
         end else begin
            logic [15:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (bus_rdata !== e) begin
               errs++;
               $display("FAIL %s: rdata=%h expected %h", t, bus_rdata, e);
            end
         end
      end
   end

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic rd(input logic [6:0] a, input logic [15:0] e, input string tag);
      @(negedge clk);
      bus_addr = a;
      bus_rd   = 1'b1;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic wr(input logic [6:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic send(input logic [7:0] b);
      @(negedge clk);
      rx_byte  = b;
      rx_valid = 1'b1;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic pulse_msg_ack();
      @(negedge clk);
      msg_ack = 1'b1;
      @(negedge clk);
      msg_ack = 1'b0;
   endtask

   task automatic pulse_err_ack();
      @(negedge clk);
      err_ack = 1'b1;
      @(negedge clk);
      err_ack = 1'b0;
   endtask

   function automatic logic [7:0] start_of(input int nparam);
      logic [3:0] len;
      len = 4'(nparam + 2);
      return {2'b00, len, 2'($countones(len))};
   endfunction

   task automatic send_msg(input logic [15:0] typ, input int nparam, input logic [7:0] base);
      send(8'hCC);
      send(start_of(nparam));
      send(typ[15:8]);
      send(typ[7:0]);
      for (int k = 0; k < nparam; k++) send(base + 8'(k));
      send(8'hCC);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errs++;
      checks++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      check("R1 msg_irq", {15'b0, msg_irq}, 16'h0);
      check("R1 err_irq", {15'b0, err_irq}, 16'h0);
      rd(7'h00, 16'h0000, "R1 pointer");
      rd(7'h01, 16'h0000, "R1 vector");
      rd(7'h02, 16'h0000, "R1 enable");

      // R2 register access
      wr(7'h01, 16'hA55A);
      rd(7'h01, 16'hA55A, "R2 vector");
      wr(7'h02, 16'hFFFF);
      rd(7'h02, 16'h0001, "R2 enable bit only");
      for (int i = 0; i < 8; i++) wr(7'(8 + i), 16'h1000 + 16'(i));
      rd(7'h08, 16'h1000, "R2 event 0");
      rd(7'h0F, 16'h1007, "R2 event 7");
      wr(7'h00, 16'h1234);
      rd(7'h00, 16'h0000, "R2 pointer write ignored");
      wr(7'h10, 16'hBEEF);

      // R10 enable off: no request, pointer still moves (R7)
      wr(7'h02, 16'h0000);
      send_msg(16'h1003, 3, 8'h20);
      check("R10 no request with enable low", {15'b0, msg_irq}, 16'h0);
      rd(7'h00, 16'h0010, "R7 pointer first block");
      rd(7'h10, 16'h1003, "R2 R6 buffer write ignored, type stored");
      rd(7'h11, 16'h2021, "R6 params packed high first");

      // R7 second message with enable on
      wr(7'h02, 16'h0001);
      send_msg(16'h1005, 2, 8'h40);
      check("R10 message request raised", {15'b0, msg_irq}, 16'h1);
      rd(7'h00, 16'h0018, "R7 pointer second block");
      rd(7'h18, 16'h1005, "R6 type word");
      rd(7'h19, 16'h4041, "R6 param word");
      pulse_err_ack();
      check("R10 error ack leaves message request", {15'b0, msg_irq}, 16'h1);
      pulse_msg_ack();
      check("R10 message ack clears", {15'b0, msg_irq}, 16'h0);

      // R8 non-matching type
      send_msg(16'h2222, 1, 8'h55);
      check("R8 no request for unmatched type", {15'b0, msg_irq}, 16'h0);
      rd(7'h00, 16'h0018, "R8 pointer unchanged");
      send_msg(16'h1000, 0, 8'h00);
      rd(7'h00, 16'h0028, "R8 unmatched message used a block");
      rd(7'h28, 16'h1000, "R6 header only message");
      pulse_msg_ack();

      // R3 start byte without preceding fill byte
      send(8'h55);
      send(8'h09);
      send(8'h10);
      send(8'h01);
      send(8'hCC);
      check("R3 no message request", {15'b0, msg_irq}, 16'h0);
      check("R3 no error request", {15'b0, err_irq}, 16'h0);
      rd(7'h00, 16'h0028, "R3 pointer unchanged");

      // R4 bad checksum, then too short a count
      send(8'hCC);
      send(8'h08);
      check("R4 checksum error", {15'b0, err_irq}, 16'h1);
      check("R4 no message request", {15'b0, msg_irq}, 16'h0);
      pulse_err_ack();
      check("R10 error ack clears", {15'b0, err_irq}, 16'h0);
      send(8'hCC);
      send(8'h05);
      check("R4 count below two", {15'b0, err_irq}, 16'h1);
      pulse_err_ack();

      // R5 missing closing fill byte
      send(8'hCC);
      send(8'h0E);
      send(8'h10);
      send(8'h01);
      send(8'h77);
      send(8'h55);
      check("R5 framing error", {15'b0, err_irq}, 16'h1);
      check("R5 no message request", {15'b0, msg_irq}, 16'h0);
      pulse_err_ack();
      send_msg(16'h1002, 1, 8'h99);
      rd(7'h00, 16'h0030, "R5 discarded message block reused");
      rd(7'h30, 16'h1002, "R5 new type in reused block");
      pulse_msg_ack();

      // R9 ring wrap
      for (int i = 0; i < 9; i++) begin
         send_msg(16'h1004, 0, 8'h00);
         pulse_msg_ack();
      end
      rd(7'h00, 16'h0078, "R9 last block");
      send_msg(16'h1007, 0, 8'h00);
      rd(7'h00, 16'h0010, "R9 wrap to first block");
      rd(7'h10, 16'h1007, "R9 first block overwritten");
      check("R10 request after wrap", {15'b0, msg_irq}, 16'h1);

      repeat (3) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule